// File: doc/BRIEF.md
# Shared Y-Space Dual-Port Data RAM

This block is a small data memory that two masters reach at once: the processor on one port and a DMA engine on the other. It sits at the top of the Y data space. The processor addresses it with full 16-bit byte addresses and the block claims an access only when the upper address bits match a base parameter. The DMA engine addresses it with a local word offset. Neither port ever waits. Each port can read or write every cycle, with separate read data, and no handshake exists on either side.

Both ports may write the same word in the same cycle. Each byte lane is then resolved on its own. Where both ports enable the lane, the processor's byte is stored and the DMA byte is discarded. A DMA byte in a lane the processor does not touch is still written. The cycle after such an overlap, a one-cycle collision pulse tells the DMA side that some of its data was lost. With the DMA port idle, the block is ordinary processor data storage.

Top module: `ydma_shared_ram`

## Requirements
- R1: While `rst_n` is low at a rising edge, `cpu_rdata`, `dma_rdata` and `dma_collide` are 0 after that edge. The memory contents are not cleared.
- R2: `cpu_sel` is high, combinationally, exactly when `cpu_addr[15:11]` equals `BASE_ADDR[15:11]` (default base 16'hF800, 2048 bytes). The word used is `cpu_addr[10:1]`, so the last word of the space (16'hFFFE) is DMA offset 1023.
- R3: A processor write with `cpu_sel` low changes no stored word. A processor read with `cpu_sel` low returns 0 in `cpu_rdata` one cycle later.
- R4: A read (`*_en`=1, `*_we`=0) loads its port's read data at the next edge with the word as stored before that edge's writes. A port's read data holds its value in any cycle without a read on that port.
- R5: A word written through one port can be read through the other port. DMA offset N is the same word as processor address `BASE_ADDR + 2*N`.
- R6: Writes from both ports to different words in the same cycle both complete.
- R7: When both ports write the same word in one cycle, every lane enabled by both ports takes the processor's byte. Lanes enabled only by the DMA port take the DMA byte.
- R8: `dma_collide` is high for the cycle after an edge at which both ports wrote the same word with at least one common enabled lane, and is low after every other edge.
- R9: Byte enables select lanes. Bit 0 writes data bits [7:0] and bit 1 writes bits [15:8]. A lane whose enable is 0 keeps its value, and a write with no lane enabled changes nothing and raises no collision.
- R10: Both ports may read the same word in the same cycle and each receives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_en | input | 1 | Processor access in this cycle |
| cpu_we | input | 1 | Processor access is a write |
| cpu_be | input | 2 | Processor byte-lane enables |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_sel | output | 1 | Address falls inside this region |
| cpu_rdata | output | 16 | Processor read data, one cycle after the read |
| dma_en | input | 1 | DMA access in this cycle |
| dma_we | input | 1 | DMA access is a write |
| dma_be | input | 2 | DMA byte-lane enables |
| dma_off | input | 10 | DMA word offset inside the region |
| dma_wdata | input | 16 | DMA write data |
| dma_rdata | output | 16 | DMA read data, one cycle after the read |
| dma_collide | output | 1 | One-cycle pulse after a lane lost to the processor |

## Verification
The checker relies on every control input being 0 or 1 at each rising edge and on `rst_n` being low at the first edge. Only under that condition do the hold and pulse properties have a defined previous cycle. The stimulus changes inputs only on falling edges. It opens with reset held low and drives every enable to an explicit 0 when a port is idle, so no property ever sees an undriven control. Each read in the stimulus targets a word that an earlier vector wrote. This keeps the read data defined, because the block never clears its storage.

// File: rtl/ydma_shared_ram_pkg.sv
// Package: shared types for the dual-port Y-space data RAM.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package ydma_shared_ram_pkg;

    // Per-lane write decision produced by the lane arbiter.
    typedef struct packed {
        logic cpu_wr;   // processor byte is written in this lane
        logic dma_wr;   // DMA byte is written in this lane
        logic lost;     // DMA byte was dropped in favour of the processor
    } lane_grant_t;

endpackage

// File: rtl/ydma_addr_decode.sv
// Module: processor-side address decode.
// Compares the upper byte-address bits with the region base and extracts
// the word index. Assumes BASE_ADDR is aligned to the region size.
module ydma_addr_decode #(
    parameter int          ADDR_W    = 16,
    parameter int          IDX_W     = 10,
    parameter int          OFF_LSB   = 1,
    parameter logic [15:0] BASE_ADDR = 16'hF800
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int TAG_LSB = OFF_LSB + IDX_W;

    logic unused_lsb;

    // Region hit: upper bits equal the base's upper bits.
    always_comb sel = (addr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);

    // Word index inside the region.
    always_comb idx = addr[TAG_LSB-1:OFF_LSB];

    // Byte-offset bits select nothing on a word-wide port.
    always_comb unused_lsb = ^addr[OFF_LSB-1:0];
endmodule

// File: rtl/ydma_lane_arbiter.sv
// Module: per-byte-lane write arbitration between the two ports.
// The processor always wins a lane that both ports write on the same word.
// Assumes the write strobes already include the region select.
module ydma_lane_arbiter
    import ydma_shared_ram_pkg::*;
#(
    parameter int LANES = 2,
    parameter int IDX_W = 10
) (
    input  logic              cpu_wr,
    input  logic [LANES-1:0]  cpu_be,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              dma_wr,
    input  logic [LANES-1:0]  dma_be,
    input  logic [IDX_W-1:0]  dma_idx,
    output lane_grant_t [LANES-1:0] grant,
    output logic              clash
);
    logic             same_word;
    logic [LANES-1:0] lost_vec;

    // Both ports point at the same word.
    always_comb same_word = (cpu_idx == dma_idx);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane decision: the processor has priority on a shared lane.
        always_comb begin
            grant[l].cpu_wr = cpu_wr & cpu_be[l];
            grant[l].lost   = dma_wr & dma_be[l] & grant[l].cpu_wr & same_word;
            grant[l].dma_wr = dma_wr & dma_be[l] & ~grant[l].lost;
            lost_vec[l]     = grant[l].lost;
        end
    end

    // Any lane lost by the DMA port is a collision.
    always_comb clash = |lost_vec;
endmodule

// File: rtl/ydma_lane_mem.sv
// Module: one byte lane of storage with two write and two read ports.
// Reads are asynchronous and give the value held before the edge's writes.
// Assumes the arbiter never lets both ports write the same word; storage is
// deliberately not reset.
module ydma_lane_mem #(
    parameter int WORDS  = 1024,
    parameter int IDX_W  = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              cpu_wr,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [LANE_W-1:0] cpu_d,
    output logic [LANE_W-1:0] cpu_q,
    input  logic              dma_wr,
    input  logic [IDX_W-1:0]  dma_idx,
    input  logic [LANE_W-1:0] dma_d,
    output logic [LANE_W-1:0] dma_q
);
    logic [LANE_W-1:0] cells [WORDS];

    // Store granted bytes; the processor write is last, matching its priority.
    always_ff @(posedge clk) begin
        if (dma_wr) cells[dma_idx] <= dma_d;
        if (cpu_wr) cells[cpu_idx] <= cpu_d;
    end

    // Present the current contents to both ports.
    always_comb cpu_q = cells[cpu_idx];
    always_comb dma_q = cells[dma_idx];
endmodule

// File: rtl/ydma_shared_ram.sv
// Module: dual-port data RAM at the top of Y space, shared by the processor
// and a DMA engine with no stalls on either side. A same-word write
// overlap is resolved per lane in favour of the processor and reported by a
// one-cycle pulse. Assumes synchronous active-low reset; the contents survive reset.
module ydma_shared_ram
    import ydma_shared_ram_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          LANE_W     = 8,
    parameter int          LANES      = 2,
    parameter int          SIZE_BYTES = 2048,
    parameter logic [15:0] BASE_ADDR  = 16'hF800,
    localparam int         DATA_W     = LANE_W * LANES,
    localparam int         WORDS      = SIZE_BYTES / LANES,
    localparam int         IDX_W      = $clog2(WORDS),
    localparam int         OFF_LSB    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_en,
    input  logic              cpu_we,
    input  logic [LANES-1:0]  cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_sel,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dma_en,
    input  logic              dma_we,
    input  logic [LANES-1:0]  dma_be,
    input  logic [IDX_W-1:0]  dma_off,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_collide
);
    logic [IDX_W-1:0]  cpu_idx;
    logic              cpu_wr;
    logic              dma_wr;
    logic              clash;
    logic [DATA_W-1:0] cpu_word;
    logic [DATA_W-1:0] dma_word;
    lane_grant_t [LANES-1:0] grant;

    ydma_addr_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .OFF_LSB  (OFF_LSB),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(cpu_addr),
        .sel (cpu_sel),
        .idx (cpu_idx)
    );

    // Write strobes; a processor write outside the region is dropped.
    always_comb cpu_wr = cpu_en & cpu_we & cpu_sel;
    always_comb dma_wr = dma_en & dma_we;

    ydma_lane_arbiter #(
        .LANES(LANES),
        .IDX_W(IDX_W)
    ) u_arb (
        .cpu_wr (cpu_wr),
        .cpu_be (cpu_be),
        .cpu_idx(cpu_idx),
        .dma_wr (dma_wr),
        .dma_be (dma_be),
        .dma_idx(dma_off),
        .grant  (grant),
        .clash  (clash)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_mem
        ydma_lane_mem #(
            .WORDS (WORDS),
            .IDX_W (IDX_W),
            .LANE_W(LANE_W)
        ) u_lane (
            .clk    (clk),
            .cpu_wr (grant[l].cpu_wr),
            .cpu_idx(cpu_idx),
            .cpu_d  (cpu_wdata[l*LANE_W +: LANE_W]),
            .cpu_q  (cpu_word[l*LANE_W +: LANE_W]),
            .dma_wr (grant[l].dma_wr),
            .dma_idx(dma_off),
            .dma_d  (dma_wdata[l*LANE_W +: LANE_W]),
            .dma_q  (dma_word[l*LANE_W +: LANE_W])
        );
    end

    // Processor read register: loaded on reads only, zero on a region miss.
    always_ff @(posedge clk) begin
        if (!rst_n)                cpu_rdata <= '0;
        else if (cpu_en && !cpu_we) cpu_rdata <= cpu_sel ? cpu_word : '0;
    end

    // DMA read register: loaded on reads only.
    always_ff @(posedge clk) begin
        if (!rst_n)                dma_rdata <= '0;
        else if (dma_en && !dma_we) dma_rdata <= dma_word;
    end

    // Collision pulse: one cycle per edge with a lost DMA lane.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_collide <= 1'b0;
        else        dma_collide <= clash;
    end
endmodule

// File: rtl/ydma_shared_ram_chk.sv
// Module: property checker bound to ydma_shared_ram.
// Observes only the ports. Assumes the controls are 0 or 1 at every edge.
module ydma_shared_ram_chk #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          LANES     = 2,
    parameter int          IDX_W     = 10,
    parameter int          OFF_LSB   = 1,
    parameter logic [15:0] BASE_ADDR = 16'hF800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_en,
    input logic              cpu_we,
    input logic [LANES-1:0]  cpu_be,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_sel,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              dma_en,
    input logic              dma_we,
    input logic [LANES-1:0]  dma_be,
    input logic [IDX_W-1:0]  dma_off,
    input logic [DATA_W-1:0] dma_rdata,
    input logic              dma_collide
);
    localparam int TAG_LSB = OFF_LSB + IDX_W;

    logic overlap_wr;
    logic unused_bits;

    // Same-word writes from both ports with a common lane.
    always_comb overlap_wr = cpu_en && cpu_we && cpu_sel && dma_en && dma_we
                             && (cpu_addr[TAG_LSB-1:OFF_LSB] == dma_off)
                             && (|(cpu_be & dma_be));
    always_comb unused_bits = ^{cpu_addr[ADDR_W-1:TAG_LSB], cpu_addr[OFF_LSB-1:0], BASE_ADDR};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cpu_rdata == '0 && dma_rdata == '0 && !dma_collide));

    // R3
    miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && !cpu_we && !cpu_sel) |=> (cpu_rdata == '0));

    // R4
    cpu_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_en && !cpu_we) |=> $stable(cpu_rdata));

    // R4
    dma_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_en && !dma_we) |=> $stable(dma_rdata));

    // R8
    collide_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_wr |=> dma_collide);

    // R8
    collide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !overlap_wr |=> !dma_collide);
endmodule

bind ydma_shared_ram ydma_shared_ram_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANES    (LANES),
    .IDX_W    (IDX_W),
    .OFF_LSB  (OFF_LSB),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_en     (cpu_en),
    .cpu_we     (cpu_we),
    .cpu_be     (cpu_be),
    .cpu_addr   (cpu_addr),
    .cpu_sel    (cpu_sel),
    .cpu_rdata  (cpu_rdata),
    .dma_en     (dma_en),
    .dma_we     (dma_we),
    .dma_be     (dma_be),
    .dma_off    (dma_off),
    .dma_rdata  (dma_rdata),
    .dma_collide(dma_collide)
);

// File: tb/ydma_shared_ram_tb.sv
// Bench: vector table for both ports, then directed reset and decode checks.
module ydma_shared_ram_tb;
    typedef struct packed {
        logic [23:0] tag;
        logic        c_en;
        logic        c_we;
        logic [1:0]  c_be;
        logic [15:0] c_addr;
        logic [15:0] c_wd;
        logic        d_en;
        logic        d_we;
        logic [1:0]  d_be;
        logic [9:0]  d_off;
        logic [15:0] d_wd;
        logic [15:0] x_c;
        logic [15:0] x_d;
        logic        x_col;
    } vec_t;

    localparam int NVEC = 16;
    // Expected values are the outputs right after the vector's clock edge.
    localparam vec_t VEC [NVEC] = '{
        '{" R6", 1'b1, 1'b1, 2'b11, 16'hF800, 16'h1234, 1'b1, 1'b1, 2'b11, 10'd5,    16'hABCD, 16'h0000, 16'h0000, 1'b0},
        '{"R10", 1'b1, 1'b0, 2'b11, 16'hF800, 16'h0000, 1'b1, 1'b0, 2'b11, 10'd0,    16'h0000, 16'h1234, 16'h1234, 1'b0},
        '{" R5", 1'b1, 1'b0, 2'b11, 16'hF80A, 16'h0000, 1'b1, 1'b0, 2'b11, 10'd5,    16'h0000, 16'hABCD, 16'hABCD, 1'b0},
        '{" R8", 1'b1, 1'b1, 2'b11, 16'hF810, 16'h1111, 1'b1, 1'b1, 2'b11, 10'd8,    16'h2222, 16'hABCD, 16'hABCD, 1'b1},
        '{" R7", 1'b1, 1'b0, 2'b11, 16'hF810, 16'h0000, 1'b0, 1'b0, 2'b00, 10'd0,    16'h0000, 16'h1111, 16'hABCD, 1'b0},
        '{" R9", 1'b1, 1'b1, 2'b11, 16'hF812, 16'h3344, 1'b0, 1'b0, 2'b00, 10'd0,    16'h0000, 16'h1111, 16'hABCD, 1'b0},
        '{" R9", 1'b1, 1'b1, 2'b01, 16'hF812, 16'h00AA, 1'b1, 1'b1, 2'b10, 10'd9,    16'hBB00, 16'h1111, 16'hABCD, 1'b0},
        '{" R8", 1'b1, 1'b1, 2'b10, 16'hF812, 16'hCC00, 1'b1, 1'b1, 2'b11, 10'd9,    16'hDDEE, 16'h1111, 16'hABCD, 1'b1},
        '{" R7", 1'b1, 1'b0, 2'b11, 16'hF812, 16'h0000, 1'b1, 1'b0, 2'b11, 10'd9,    16'h0000, 16'hCCEE, 16'hCCEE, 1'b0},
        '{" R4", 1'b1, 1'b1, 2'b11, 16'hF812, 16'h5555, 1'b1, 1'b0, 2'b11, 10'd9,    16'h0000, 16'hCCEE, 16'hCCEE, 1'b0},
        '{" R3", 1'b1, 1'b1, 2'b11, 16'h1012, 16'hFFFF, 1'b1, 1'b0, 2'b11, 10'd9,    16'h0000, 16'hCCEE, 16'h5555, 1'b0},
        '{" R3", 1'b1, 1'b0, 2'b11, 16'h1012, 16'h0000, 1'b1, 1'b0, 2'b11, 10'd9,    16'h0000, 16'h0000, 16'h5555, 1'b0},
        '{" R4", 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0000, 1'b1, 1'b1, 2'b11, 10'd1023, 16'h7E7E, 16'h0000, 16'h5555, 1'b0},
        '{" R2", 1'b1, 1'b0, 2'b11, 16'hFFFE, 16'h0000, 1'b0, 1'b0, 2'b00, 10'd0,    16'h0000, 16'h7E7E, 16'h5555, 1'b0},
        '{" R9", 1'b1, 1'b1, 2'b00, 16'hF806, 16'h1234, 1'b1, 1'b1, 2'b11, 10'd3,    16'h0F0F, 16'h7E7E, 16'h5555, 1'b0},
        '{" R9", 1'b1, 1'b0, 2'b11, 16'hF806, 16'h0000, 1'b1, 1'b0, 2'b11, 10'd3,    16'h0000, 16'h0F0F, 16'h0F0F, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_en = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_be = '0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_sel;
    logic [15:0] cpu_rdata;
    logic        dma_en = 1'b0, dma_we = 1'b0;
    logic [1:0]  dma_be = '0;
    logic [9:0]  dma_off = '0;
    logic [15:0] dma_wdata = '0;
    logic [15:0] dma_rdata;
    logic        dma_collide;
    int          checks = 0;
    int          fails = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    ydma_shared_ram u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_sel(cpu_sel), .cpu_rdata(cpu_rdata),
        .dma_en(dma_en), .dma_we(dma_we), .dma_be(dma_be), .dma_off(dma_off),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_collide(dma_collide)
    );

    task automatic check_outs(input string req, input logic [15:0] xc,
                              input logic [15:0] xd, input logic xcol);
        checks++;
        if (cpu_rdata !== xc || dma_rdata !== xd || dma_collide !== xcol) begin
            fails++;
            $display("FAIL %s: cpu_rdata=%h dma_rdata=%h collide=%b, expected %h %h %b",
                     req, cpu_rdata, dma_rdata, dma_collide, xc, xd, xcol);
        end
    endtask

    task automatic check_sel(input logic [15:0] a, input logic xs);
        cpu_addr = a;
        #1;
        checks++;
        if (cpu_sel !== xs) begin
            fails++;
            $display("FAIL R2: cpu_sel=%b for addr %h, expected %b", cpu_sel, a, xs);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        check_outs("R1", 16'h0000, 16'h0000, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            cpu_en = VEC[i].c_en;  cpu_we = VEC[i].c_we;  cpu_be = VEC[i].c_be;
            cpu_addr = VEC[i].c_addr;  cpu_wdata = VEC[i].c_wd;
            dma_en = VEC[i].d_en;  dma_we = VEC[i].d_we;  dma_be = VEC[i].d_be;
            dma_off = VEC[i].d_off;  dma_wdata = VEC[i].d_wd;
            @(negedge clk);
            check_outs(string'(VEC[i].tag), VEC[i].x_c, VEC[i].x_d, VEC[i].x_col);
        end
        cpu_en = 1'b0; dma_en = 1'b0;
        // R2: decode at the region edges
        check_sel(16'hF800, 1'b1);
        check_sel(16'hFFFF, 1'b1);
        check_sel(16'hF7FE, 1'b0);
        check_sel(16'h0800, 1'b0);
        // R1: reset in mid-run clears the read registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_outs("R1", 16'h0000, 16'h0000, 1'b0);
        rst_n = 1'b1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule